// File: doc/BRIEF.md
# Call Frame Stack and Target Resolver

This block handles the control-transfer side of a register-based bytecode machine: direct calls, indirect calls and returns. A direct call carries a 32-bit hash of the callee's name. The block compares that hash against two tables that are filled before the program starts. The first table lists host services and the second lists in-program entry points. A host-service hit wins over an entry-point hit. It does not create a frame. Instead it raises a service request that is held until the host acknowledges it, and execution then resumes after the call. An entry-point hit pushes a frame and jumps to the stored address.

An indirect call names a general register through its immediate. The block reads that register and jumps to the absolute address it holds. Every frame-creating call saves the return address and the caller's stack pointer on a shadow stack that no instruction can reach. It also moves the stack pointer on by a fixed frame size. A return pops the newest frame. A return with no frame left ends the program cleanly.

Any unresolvable hash, bad register index or stack overflow stops the machine with a coded abort. The abort stays set until reset.

Top module: `call_frame_unit`

## Requirements
- R1: A direct call (opcode 0x85) whose immediate matches a valid host-service entry raises `sys_req` with `sys_idx` equal to that entry's slot on the cycle after the instruction. It pushes no frame and leaves `sp` unchanged. `sys_req` stays high with a stable index until `sys_ack`.
- R2: On the cycle after `sys_ack` is seen with `sys_req` high, `sys_req` drops and `next_pc_valid` pulses with `next_pc` equal to the call's PC plus 1.
- R3: When a hash is present in both tables, the host-service match takes precedence.
- R4: A direct call that hits only the entry-point table, with frames to spare, pulses `next_pc_valid` one cycle later with `next_pc` equal to the stored target. It pushes a frame of {PC+1, old `sp`} and adds FRAME_SZ to `sp`.
- R5: A direct call matching neither table sets `abort` with `abort_code` 1. Abort is sticky, and every later instruction is ignored.
- R6: An indirect call (opcode 0x8D) with an immediate of at most 10 drives `gpr_idx` with immediate bits [3:0]. It jumps to the low ADDR_W bits of `gpr_data` and pushes a frame exactly as R4 does.
- R7: An indirect call whose 32-bit immediate exceeds 10 sets `abort` with `abort_code` 3.
- R8: An exit (opcode 0x95) with at least one frame pulses `next_pc_valid` with the saved return PC and restores the saved `sp`.
- R9: An exit with no frame sets the sticky `done` flag without abort and produces no `next_pc_valid`.
- R10: A frame-creating call when DEPTH frames are held sets `abort` with `abort_code` 2 and leaves `sp` unchanged.
- R11: Table writes are accepted only until the first `insn_valid` after reset. Later writes have no effect on resolution.
- R12: Other opcodes, and any instruction presented while `sys_req` is high, produce no output change.
- R13: After reset, `next_pc_valid`, `sys_req`, `abort` and `done` are low, `abort_code` is 0, and `sp` equals SP_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_jump | input | 1 | 0 selects the host-service table, 1 the entry-point table |
| tbl_wr_slot | input | $clog2(N_SLOTS) | Entry slot to write |
| tbl_wr_hash | input | 32 | Name hash of the entry |
| tbl_wr_target | input | ADDR_W | Jump address (entry-point table only) |
| insn_valid | input | 1 | Instruction presented this cycle |
| insn_opcode | input | 8 | Instruction opcode |
| insn_imm | input | 32 | Instruction immediate |
| insn_pc | input | ADDR_W | Address of the instruction |
| gpr_idx | output | 4 | Register index read for an indirect call |
| gpr_data | input | GPR_W | Value of register `gpr_idx` |
| sys_ack | input | 1 | Host finished the service request |
| next_pc_valid | output | 1 | One-cycle pulse: `next_pc` is the new PC |
| next_pc | output | ADDR_W | Redirect address |
| sys_req | output | 1 | Host service requested |
| sys_idx | output | $clog2(N_SLOTS) | Host-service table slot |
| abort | output | 1 | Sticky abort |
| abort_code | output | 2 | 1 unresolved, 2 overflow, 3 bad register |
| done | output | 1 | Sticky normal completion |
| sp | output | ADDR_W | Current stack pointer |

## Verification
Every result is registered once, so the effect of an instruction presented before a rising edge can be read on the following falling edge. A service acknowledgement likewise resolves one edge later. Each bench task drives inputs on a falling edge and samples right after the next falling edge. Held conditions such as a pending service request or a sticky abort are sampled again on later cycles, after stimulus that could have disturbed them.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam logic [7:0]  OPC_CALL  = 8'h85;
  localparam logic [7:0]  OPC_CALLX = 8'h8D;
  localparam logic [7:0]  OPC_EXIT  = 8'h95;
  localparam logic [31:0] MAX_GPR   = 32'd10;

  typedef enum logic [1:0] {
    ABT_NONE       = 2'd0,
    ABT_UNRESOLVED = 2'd1,
    ABT_OVERFLOW   = 2'd2,
    ABT_BADREG     = 2'd3
  } abort_e;
endpackage

// File: rtl/cfu_hash_table.sv
module cfu_hash_table #(
  parameter int N        = 4,
  parameter int TGT_W    = 32,
  parameter bit KEEP_TGT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_slot,
  input  logic [31:0]          wr_hash,
  input  logic [TGT_W-1:0]     wr_tgt,
  input  logic [31:0]          key,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_slot,
  output logic [TGT_W-1:0]     hit_tgt
);
  localparam int IW = $clog2(N);

  logic [N-1:0]     vld;
  logic [31:0]      hsh [N];
  logic [TGT_W-1:0] tgt [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < N; i++) hsh[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (wr_slot == IW'(i)) begin
          vld[i] <= 1'b1;
          hsh[i] <= wr_hash;
        end
      end
    end
  end

  generate
    if (KEEP_TGT) begin : g_tgt
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < N; i++) tgt[i] <= '0;
        end else if (wr_en) begin
          for (int i = 0; i < N; i++)
            if (wr_slot == IW'(i)) tgt[i] <= wr_tgt;
        end
      end
    end else begin : g_no_tgt
      logic unused_tgt;
      assign unused_tgt = ^wr_tgt;
      for (genvar g = 0; g < N; g++) begin : g_zero
        assign tgt[g] = '0;
      end
    end
  endgenerate

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (hsh[g] == key);
  end

  // lowest matching slot wins
  always_comb begin
    hit      = |match;
    hit_slot = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) hit_slot = IW'(i);
    hit_tgt = tgt[hit_slot];
  end

  // R11
  slot_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_slot)]);
endmodule

// File: rtl/cfu_frame_stack.sv
module cfu_frame_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [W-1:0]             push_ret,
  input  logic [W-1:0]             push_sp,
  output logic [W-1:0]             top_ret,
  output logic [W-1:0]             top_sp,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  ret_mem [DEPTH];
  logic [W-1:0]  sp_mem  [DEPTH];
  logic [CW-1:0] top_i;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign top_i = count - 1'b1;
  assign top_ret = ret_mem[top_i[IW-1:0]];
  assign top_sp  = sp_mem[top_i[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ret_mem[i] <= '0;
        sp_mem[i]  <= '0;
      end
    end else if (push) begin
      ret_mem[count[IW-1:0]] <= push_ret;
      sp_mem[count[IW-1:0]]  <= push_sp;
      count <= count + 1'b1;
    end else if (pop) begin
      count <= count - 1'b1;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R8
  single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/call_frame_unit.sv
module call_frame_unit
  import cfu_pkg::*;
#(
  parameter int          N_SLOTS  = 4,
  parameter int          DEPTH    = 4,
  parameter int          ADDR_W   = 32,
  parameter int          GPR_W    = 64,
  parameter logic [31:0] SP_INIT  = 32'h0000_8000,
  parameter logic [31:0] FRAME_SZ = 32'h0000_0100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_wr_en,
  input  logic                       tbl_wr_jump,
  input  logic [$clog2(N_SLOTS)-1:0] tbl_wr_slot,
  input  logic [31:0]                tbl_wr_hash,
  input  logic [ADDR_W-1:0]          tbl_wr_target,
  input  logic                       insn_valid,
  input  logic [7:0]                 insn_opcode,
  input  logic [31:0]                insn_imm,
  input  logic [ADDR_W-1:0]          insn_pc,
  output logic [3:0]                 gpr_idx,
  input  logic [GPR_W-1:0]           gpr_data,
  input  logic                       sys_ack,
  output logic                       next_pc_valid,
  output logic [ADDR_W-1:0]          next_pc,
  output logic                       sys_req,
  output logic [$clog2(N_SLOTS)-1:0] sys_idx,
  output logic                       abort,
  output logic [1:0]                 abort_code,
  output logic                       done,
  output logic [ADDR_W-1:0]          sp
);
  localparam int SW = $clog2(N_SLOTS);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [ADDR_W-1:0] ret_addr(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] sp_grow(input logic [ADDR_W-1:0] cur);
    return cur + FRAME_SZ[ADDR_W-1:0];
  endfunction

  logic lock_q, halted;
  logic [ADDR_W-1:0] sys_ret_q;
  logic unused_gpr_hi;

  logic          sys_hit, jmp_hit;
  logic [SW-1:0] sys_slot, jmp_slot;
  logic [ADDR_W-1:0] jmp_tgt, sys_tgt_nc;
  logic [ADDR_W-1:0] stk_ret, stk_sp;
  logic stk_full, stk_empty;
  logic [CW-1:0] stk_count;

  assign unused_gpr_hi = ^{gpr_data[GPR_W-1:ADDR_W], sys_tgt_nc};
  assign halted  = abort | done;
  assign gpr_idx = insn_imm[3:0];

  cfu_hash_table #(.N(N_SLOTS), .TGT_W(ADDR_W), .KEEP_TGT(1'b0)) u_sys_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en && !lock_q && !tbl_wr_jump),
    .wr_slot(tbl_wr_slot), .wr_hash(tbl_wr_hash), .wr_tgt(tbl_wr_target),
    .key(insn_imm), .hit(sys_hit), .hit_slot(sys_slot), .hit_tgt(sys_tgt_nc)
  );

  cfu_hash_table #(.N(N_SLOTS), .TGT_W(ADDR_W), .KEEP_TGT(1'b1)) u_jmp_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en && !lock_q && tbl_wr_jump),
    .wr_slot(tbl_wr_slot), .wr_hash(tbl_wr_hash), .wr_tgt(tbl_wr_target),
    .key(insn_imm), .hit(jmp_hit), .hit_slot(jmp_slot), .hit_tgt(jmp_tgt)
  );

  // decoded events, exposed for the assertions
  logic accept, is_call, is_callx, is_exit, idx_bad;
  logic ev_sys, ev_jmp, ev_indir, ev_unres, ev_ovf, ev_badreg, ev_ret, ev_fin;
  logic stk_push, stk_pop;
  logic unused_jslot;

  assign unused_jslot = ^jmp_slot;
  assign accept    = insn_valid && !halted && !sys_req;
  assign is_call   = (insn_opcode == OPC_CALL);
  assign is_callx  = (insn_opcode == OPC_CALLX);
  assign is_exit   = (insn_opcode == OPC_EXIT);
  assign idx_bad   = (insn_imm > MAX_GPR);

  assign ev_sys    = accept && is_call && sys_hit;
  assign ev_unres  = accept && is_call && !sys_hit && !jmp_hit;
  assign ev_jmp    = accept && is_call && !sys_hit && jmp_hit && !stk_full;
  assign ev_badreg = accept && is_callx && idx_bad;
  assign ev_indir  = accept && is_callx && !idx_bad && !stk_full;
  assign ev_ovf    = accept && stk_full &&
                     ((is_call && !sys_hit && jmp_hit) || (is_callx && !idx_bad));
  assign ev_ret    = accept && is_exit && !stk_empty;
  assign ev_fin    = accept && is_exit && stk_empty;

  assign stk_push = ev_jmp | ev_indir;
  assign stk_pop  = ev_ret;

  cfu_frame_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(stk_push), .pop(stk_pop),
    .push_ret(ret_addr(insn_pc)), .push_sp(sp),
    .top_ret(stk_ret), .top_sp(stk_sp),
    .full(stk_full), .empty(stk_empty), .count(stk_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q        <= 1'b0;
      next_pc_valid <= 1'b0;
      next_pc       <= '0;
      sys_req       <= 1'b0;
      sys_idx       <= '0;
      sys_ret_q     <= '0;
      abort         <= 1'b0;
      abort_code    <= ABT_NONE;
      done          <= 1'b0;
      sp            <= SP_INIT[ADDR_W-1:0];
    end else begin
      next_pc_valid <= 1'b0;
      if (insn_valid) lock_q <= 1'b1;
      if (sys_req && sys_ack) begin
        sys_req       <= 1'b0;
        next_pc_valid <= 1'b1;
        next_pc       <= sys_ret_q;
      end
      if (ev_sys) begin
        sys_req   <= 1'b1;
        sys_idx   <= sys_slot;
        sys_ret_q <= ret_addr(insn_pc);
      end
      if (ev_jmp) begin
        next_pc_valid <= 1'b1;
        next_pc       <= jmp_tgt;
        sp            <= sp_grow(sp);
      end
      if (ev_indir) begin
        next_pc_valid <= 1'b1;
        next_pc       <= gpr_data[ADDR_W-1:0];
        sp            <= sp_grow(sp);
      end
      if (ev_ret) begin
        next_pc_valid <= 1'b1;
        next_pc       <= stk_ret;
        sp            <= stk_sp;
      end
      if (ev_fin) done <= 1'b1;
      if (ev_unres)  begin abort <= 1'b1; abort_code <= ABT_UNRESOLVED; end
      if (ev_ovf)    begin abort <= 1'b1; abort_code <= ABT_OVERFLOW;   end
      if (ev_badreg) begin abort <= 1'b1; abort_code <= ABT_BADREG;     end
    end
  end

  // R5
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> abort && $stable(abort_code));
  // R5
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort == (abort_code != 2'd0));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R1
  sysreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && !sys_ack |=> sys_req && $stable(sys_idx));
  // R2
  sys_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && sys_ack |=> next_pc_valid && !sys_req);
  // R12
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(next_pc_valid && sys_req));
  // R4
  push_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |=> next_pc_valid && stk_count == $past(stk_count) + 1'b1);
  // R1
  sys_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sys |=> $stable(sp) && $stable(stk_count));
endmodule

// File: tb/call_frame_unit_tb.sv
module call_frame_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SP0 = 32'h0000_8000;
  localparam logic [31:0] FS  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_wr_en = 1'b0, tbl_wr_jump = 1'b0;
  logic [1:0] tbl_wr_slot = '0;
  logic [31:0] tbl_wr_hash = '0, tbl_wr_target = '0;
  logic insn_valid = 1'b0;
  logic [7:0] insn_opcode = '0;
  logic [31:0] insn_imm = '0, insn_pc = '0;
  logic [3:0] gpr_idx;
  logic [63:0] gpr_data;
  logic sys_ack = 1'b0;
  logic next_pc_valid, sys_req, abort, done;
  logic [31:0] next_pc, sp;
  logic [1:0] sys_idx, abort_code;
  logic [63:0] regs [16];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign gpr_data = regs[gpr_idx];

  call_frame_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_jump(tbl_wr_jump), .tbl_wr_slot(tbl_wr_slot),
    .tbl_wr_hash(tbl_wr_hash), .tbl_wr_target(tbl_wr_target),
    .insn_valid(insn_valid), .insn_opcode(insn_opcode), .insn_imm(insn_imm),
    .insn_pc(insn_pc), .gpr_idx(gpr_idx), .gpr_data(gpr_data), .sys_ack(sys_ack),
    .next_pc_valid(next_pc_valid), .next_pc(next_pc), .sys_req(sys_req),
    .sys_idx(sys_idx), .abort(abort), .abort_code(abort_code), .done(done), .sp(sp)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input bit jump, input logic [1:0] slot, input logic [31:0] h,
                      input logic [31:0] tgt);
    tbl_wr_en = 1'b1; tbl_wr_jump = jump; tbl_wr_slot = slot;
    tbl_wr_hash = h; tbl_wr_target = tgt;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // drive on a falling edge, result sampled on the next falling edge
  task automatic issue(input logic [7:0] opc, input logic [31:0] imm,
                       input logic [31:0] pc);
    insn_valid = 1'b1; insn_opcode = opc; insn_imm = imm; insn_pc = pc;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(!next_pc_valid && !sys_req && !abort && !done, "R13 flags",
          {next_pc_valid, sys_req, abort, done}, 0);
    check(abort_code == 0, "R13 code", abort_code, 0);
    check(sp == SP0, "R13 sp", sp, SP0);
  endtask

  task automatic t_syscall();
    do_reset();
    load(1'b0, 2'd2, 32'hA1A1_0001, 32'h0);
    issue(8'h85, 32'hA1A1_0001, 32'd100);
    check(sys_req && sys_idx == 2, "R1 request", {sys_req, sys_idx}, {1'b1, 2'd2});
    check(!next_pc_valid && sp == SP0, "R1 no frame", sp, SP0);
    @(negedge clk);
    check(sys_req && sys_idx == 2, "R1 hold", {sys_req, sys_idx}, {1'b1, 2'd2});
    issue(8'h95, 32'h0, 32'd7);
    check(sys_req && !done && !next_pc_valid, "R12 ignored while waiting",
          {sys_req, done, next_pc_valid}, 3'b100);
    sys_ack = 1'b1;
    @(negedge clk);
    sys_ack = 1'b0;
    check(next_pc_valid && next_pc == 101 && !sys_req, "R2 resume",
          next_pc, 101);
    @(negedge clk);
    check(!next_pc_valid, "R2 pulse", next_pc_valid, 0);
  endtask

  task automatic t_precedence();
    do_reset();
    load(1'b1, 2'd0, 32'hBEEF_0002, 32'h500);
    load(1'b0, 2'd1, 32'hBEEF_0002, 32'h0);
    issue(8'h85, 32'hBEEF_0002, 32'd20);
    check(sys_req && sys_idx == 1 && !next_pc_valid, "R3 syscall wins",
          {sys_req, sys_idx, next_pc_valid}, {1'b1, 2'd1, 1'b0});
  endtask

  task automatic t_jump_exit();
    do_reset();
    load(1'b1, 2'd3, 32'hC0DE_0003, 32'h2000);
    issue(8'h85, 32'hC0DE_0003, 32'd10);
    check(next_pc_valid && next_pc == 32'h2000, "R4 target", next_pc, 32'h2000);
    check(sp == SP0 + FS, "R4 sp", sp, SP0 + FS);
    issue(8'h07, 32'hC0DE_0003, 32'd11);
    check(!next_pc_valid && !sys_req && !abort && sp == SP0 + FS,
          "R12 other opcode", sp, SP0 + FS);
    issue(8'h95, 32'h0, 32'h2005);
    check(next_pc_valid && next_pc == 11, "R8 return pc", next_pc, 11);
    check(sp == SP0, "R8 sp", sp, SP0);
    issue(8'h95, 32'h0, 32'd12);
    check(done && !abort && !next_pc_valid, "R9 done",
          {done, abort, next_pc_valid}, 3'b100);
    issue(8'h85, 32'hC0DE_0003, 32'd13);
    check(done && !next_pc_valid, "R9 halted", next_pc_valid, 0);
  endtask

  task automatic t_unresolved();
    do_reset();
    load(1'b1, 2'd0, 32'h1234_5678, 32'h300);
    issue(8'h85, 32'h9999_0000, 32'd5);
    check(abort && abort_code == 1, "R5 unresolved", abort_code, 1);
    issue(8'h85, 32'h1234_5678, 32'd6);
    check(abort && abort_code == 1 && !next_pc_valid, "R5 sticky",
          {abort_code, next_pc_valid}, {2'd1, 1'b0});
  endtask

  task automatic t_indirect();
    do_reset();
    issue(8'h8D, 32'd7, 32'd50);
    check(next_pc_valid && next_pc == 32'h3000, "R6 target", next_pc, 32'h3000);
    check(sp == SP0 + FS, "R6 sp", sp, SP0 + FS);
    issue(8'h8D, 32'd10, 32'h3000);
    check(next_pc_valid && next_pc == 32'h4444 && !abort, "R6 r10", next_pc, 32'h4444);
    issue(8'h95, 32'h0, 32'h4444);
    check(next_pc == 32'h3001 && sp == SP0 + FS, "R8 inner", next_pc, 32'h3001);
    issue(8'h95, 32'h0, 32'h3001);
    check(next_pc == 51 && sp == SP0, "R8 outer", next_pc, 51);
    issue(8'h8D, 32'd11, 32'd52);
    check(abort && abort_code == 3 && !next_pc_valid, "R7 bad reg", abort_code, 3);
  endtask

  task automatic t_overflow();
    do_reset();
    load(1'b1, 2'd1, 32'h0F0F_0004, 32'h700);
    for (int i = 0; i < 4; i++) issue(8'h85, 32'h0F0F_0004, 32'(i));
    check(!abort && sp == SP0 + 4 * FS, "R10 full depth", sp, SP0 + 4 * FS);
    issue(8'h85, 32'h0F0F_0004, 32'h700);
    check(abort && abort_code == 2 && !next_pc_valid, "R10 overflow", abort_code, 2);
    check(sp == SP0 + 4 * FS, "R10 sp kept", sp, SP0 + 4 * FS);
  endtask

  task automatic t_lock();
    do_reset();
    load(1'b1, 2'd0, 32'h5555_0001, 32'h400);
    issue(8'h00, 32'h0, 32'h0);
    load(1'b1, 2'd1, 32'h6666_0002, 32'h800);
    issue(8'h85, 32'h5555_0001, 32'd1);
    check(next_pc_valid && next_pc == 32'h400, "R11 early write kept", next_pc, 32'h400);
    issue(8'h85, 32'h6666_0002, 32'd2);
    check(abort && abort_code == 1, "R11 late write ignored", abort_code, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 64'h0;
    regs[7]  = 64'hDEAD_0000_0000_3000;
    regs[10] = 64'h0000_0001_0000_4444;
    t_reset();
    t_syscall();
    t_precedence();
    t_jump_exit();
    t_unresolved();
    t_indirect();
    t_overflow();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule